// File: doc/BRIEF.md
# Discrete-Input Detector Register Interface

This block is the serial register front end of a 32-input discrete threshold detector. A host talks to it over a four-wire SPI link in mode 0. The first byte of every transaction is a command: its top bit picks read or write and its low seven bits pick a register. Data bytes follow, most significant byte first. A transaction carries one, two or four data bytes, and it ends when chip select is released.

The block holds a control register, a per-bank sensing-mode register and two 16-bit threshold/hysteresis words, one for each sensing mode. Each 16-bit word carries the hysteresis in its upper byte and the sum of the rising and falling thresholds in its lower byte. These registers drive the comparator logic directly through output ports. The 32 comparator results come back in on `chanState`. They can be read as one 32-bit word or as four byte-wide registers.

The SPI pins are oversampled by the system clock through synchronisers, so the whole block runs in one clock domain. A control bit holds the other registers at their power-up values. The host sets that bit and then clears it to perform a software reset.

Top module: `spi_detector_regs`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 are the register address. The MOSI bytes that follow a read command change no register.
- R2: Multi-byte data is sent most significant byte first. A 16-bit write is the command byte, then the high byte, then the low byte. A 16-bit read returns the high byte first.
- R3: Address 0x02 is control. Bit 0 is a test flag, driven on `testMode`. Bit 1 is the software-reset request. Bits 7:2 read as 0.
- R4: Address 0x04 is the sensing mode. Bit n drives `bankMode[n]` and covers channels 8n..8n+7, with 1 = supply-open and 0 = ground-open. Bits 7:4 read as 0.
- R5: Addresses 0x10, 0x12, 0x14 and 0x16 read channel states 7:0, 15:8, 23:16 and 31:24. A 4-byte read of 0x78 returns all 32 states, byte 31:24 first, with bit i equal to channel i. The states are captured when the command byte completes.
- R6: Address 0x3A holds the 16-bit ground-open word, driven on `gndThresh`. Address 0x3C holds the supply-open word, driven on `supThresh`.
- R7: After `rstN`, and in every cycle after one in which control bit 1 is 1, the mode register reads 0 and both threshold words read 0x0206. The control register itself is not cleared. Writing control bit 1 back to 0 restores normal writes.
- R8: Data is sampled on rising SCLK and changed on falling SCLK. For a read, the first data bit is on MISO before the first rising edge of the first data byte. MISO is 0 while `csN` is high.
- R9: Each data byte is committed only when its eighth bit arrives. Releasing `csN` mid-byte discards that byte, while bytes already completed stay committed.
- R10: Writes to the read-only status addresses (0x10, 0x12, 0x14, 0x16, 0x78) and to unmapped addresses change nothing.
- R11: A read of an unmapped address returns 0x00. Read bytes beyond a register's width return 0x00, and write bytes beyond it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when deselected |
| chanState | input | 32 | Comparator result per channel, synchronous to clk |
| testMode | output | 1 | Control test flag |
| bankMode | output | 4 | Sensing mode per bank of eight channels |
| gndThresh | output | 16 | Ground-open hysteresis and threshold sum |
| supThresh | output | 16 | Supply-open hysteresis and threshold sum |

## Verification
The assertions assume that each SCLK level lasts several system clocks, so that a byte-complete strobe and a falling-edge shift can never fall in the same cycle. They also assume that `chanState` is synchronous to `clk`. The bench holds each SCLK phase for six clocks and changes MOSI only while SCLK is low. It changes chip select only with SCLK low and six clocks clear of any edge. It drives `chanState` only between transactions, so every capture sees settled values.

// File: rtl/spi_det_pkg.sv
package spi_det_pkg;
  localparam int IDX_W = 3;
  localparam logic [15:0] THR_INIT = 16'h0206;

  localparam logic [6:0] ADDR_CTRL      = 7'h02;
  localparam logic [6:0] ADDR_MODE      = 7'h04;
  localparam logic [6:0] ADDR_STATE_LO  = 7'h10;
  localparam logic [6:0] ADDR_STATE_ALL = 7'h78;
  localparam logic [6:0] ADDR_GND       = 7'h3A;
  localparam logic [6:0] ADDR_SUP       = 7'h3C;

  typedef struct packed {
    logic             cmdDone;
    logic             dataDone;
    logic             shiftOut;
    logic [IDX_W-1:0] byteIdx;
    logic [7:0]       rxByte;
  } ctl_strobe_t;
endpackage

// File: rtl/spi_det_ctl.sv
module spi_det_ctl
  import spi_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        mosi,
  output ctl_strobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   sclkSync;
  logic [SYNC_STAGES-1:0] csSync;
  logic [SYNC_STAGES-1:0] mosiSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-1:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
    end
  end

  logic csActive, sclkRise, sclkFall, mosiBit;
  assign csActive = ~csSync[LAST];
  assign sclkRise = sclkSync[LAST] & ~sclkSync[SYNC_STAGES];
  assign sclkFall = ~sclkSync[LAST] & sclkSync[SYNC_STAGES];
  assign mosiBit  = mosiSync[LAST];

  logic [2:0]       bitCnt;
  logic             cmdSeen;
  logic             pending;
  logic [IDX_W-1:0] byteIdx;
  logic [6:0]       rxShift;
  logic             cmdDoneQ, dataDoneQ;
  logic [7:0]       rxByteQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      cmdSeen   <= 1'b0;
      pending   <= 1'b0;
      byteIdx   <= '0;
      rxShift   <= '0;
      cmdDoneQ  <= 1'b0;
      dataDoneQ <= 1'b0;
      rxByteQ   <= '0;
      idxQ      <= '0;
    end else begin
      cmdDoneQ  <= 1'b0;
      dataDoneQ <= 1'b0;
      if (!csActive) begin
        bitCnt  <= '0;
        cmdSeen <= 1'b0;
        pending <= 1'b0;
        byteIdx <= '0;
      end else if (sclkRise) begin
        rxShift <= {rxShift[5:0], mosiBit};
        bitCnt  <= bitCnt + 3'd1;
        pending <= cmdSeen;
        if (bitCnt == 3'd7) begin
          rxByteQ <= {rxShift, mosiBit};
          idxQ    <= byteIdx;
          if (!cmdSeen) begin
            cmdSeen  <= 1'b1;
            cmdDoneQ <= 1'b1;
          end else begin
            dataDoneQ <= 1'b1;
            if (byteIdx != '1) byteIdx <= byteIdx + 1'b1;
          end
        end
      end else if (sclkFall) begin
        pending <= 1'b0;
      end
    end
  end

  assign strb.cmdDone  = cmdDoneQ;
  assign strb.dataDone = dataDoneQ;
  assign strb.shiftOut = csActive & sclkFall & pending;
  assign strb.byteIdx  = idxQ;
  assign strb.rxByte   = rxByteQ;
endmodule

// File: rtl/spi_det_dp.sv
module spi_det_dp
  import spi_det_pkg::*;
#(
  parameter int CH_COUNT  = 32,
  parameter int BANK_SIZE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobe_t         strb,
  input  logic                csN,
  input  logic [CH_COUNT-1:0] chanState,
  output logic                miso,
  output logic                testMode,
  output logic [CH_COUNT/BANK_SIZE-1:0] bankMode,
  output logic [15:0]         gndThresh,
  output logic [15:0]         supThresh,
  output logic                softRst
);
  localparam int BANKS    = CH_COUNT / BANK_SIZE;
  localparam int ST_BYTES = CH_COUNT / 8;
  localparam int TOPB     = CH_COUNT - 8;
  localparam int HALFB    = CH_COUNT - 16;

  logic             cmdRead;
  logic [6:0]       cmdAddr;
  logic [1:0]       ctrlReg;
  logic [BANKS-1:0] modeReg;
  logic [15:0]      gndReg, supReg;
  logic [CH_COUNT-1:0] txShift;

  function automatic logic [CH_COUNT-1:0] readWord(input logic [6:0] addr);
    logic [CH_COUNT-1:0] word;
    word = '0;
    if (addr == ADDR_CTRL) word[TOPB +: 2] = ctrlReg;
    if (addr == ADDR_MODE) word[TOPB +: BANKS] = modeReg;
    if (addr == ADDR_GND) word[HALFB +: 16] = gndReg;
    if (addr == ADDR_SUP) word[HALFB +: 16] = supReg;
    if (addr == ADDR_STATE_ALL) word = chanState;
    for (int b = 0; b < ST_BYTES; b++) begin
      if (addr == ADDR_STATE_LO + 7'(2 * b)) word[TOPB +: 8] = chanState[b*8 +: 8];
    end
    return word;
  endfunction

  logic writeHit;
  assign writeHit = strb.dataDone & ~cmdRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdRead <= 1'b0;
      cmdAddr <= '0;
      ctrlReg <= '0;
      modeReg <= '0;
      gndReg  <= THR_INIT;
      supReg  <= THR_INIT;
      txShift <= '0;
    end else begin
      if (strb.cmdDone) begin
        cmdRead <= strb.rxByte[7];
        cmdAddr <= strb.rxByte[6:0];
        txShift <= strb.rxByte[7] ? readWord(strb.rxByte[6:0]) : '0;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[CH_COUNT-2:0], 1'b0};
      end

      if (writeHit) begin
        unique case (cmdAddr)
          ADDR_CTRL: if (strb.byteIdx == '0) ctrlReg <= strb.rxByte[1:0];
          ADDR_MODE: if (strb.byteIdx == '0) modeReg <= strb.rxByte[BANKS-1:0];
          ADDR_GND: begin
            if (strb.byteIdx == 'd0) gndReg[15:8] <= strb.rxByte;
            if (strb.byteIdx == 'd1) gndReg[7:0]  <= strb.rxByte;
          end
          ADDR_SUP: begin
            if (strb.byteIdx == 'd0) supReg[15:8] <= strb.rxByte;
            if (strb.byteIdx == 'd1) supReg[7:0]  <= strb.rxByte;
          end
          default: ;
        endcase
      end

      if (ctrlReg[1]) begin
        modeReg <= '0;
        gndReg  <= THR_INIT;
        supReg  <= THR_INIT;
      end
    end
  end

  assign miso      = ~csN & txShift[CH_COUNT-1];
  assign testMode  = ctrlReg[0];
  assign softRst   = ctrlReg[1];
  assign bankMode  = modeReg;
  assign gndThresh = gndReg;
  assign supThresh = supReg;
endmodule

// File: rtl/spi_detector_regs.sv
module spi_detector_regs
  import spi_det_pkg::*;
#(
  parameter int CH_COUNT    = 32,
  parameter int BANK_SIZE   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                csN,
  input  logic                mosi,
  output logic                miso,
  input  logic [CH_COUNT-1:0] chanState,
  output logic                testMode,
  output logic [CH_COUNT/BANK_SIZE-1:0] bankMode,
  output logic [15:0]         gndThresh,
  output logic [15:0]         supThresh
);
  ctl_strobe_t strb;
  logic        softRst;

  spi_det_ctl #(.SYNC_STAGES(SYNC_STAGES)) i_ctl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .strb(strb)
  );

  spi_det_dp #(.CH_COUNT(CH_COUNT), .BANK_SIZE(BANK_SIZE)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .csN(csN), .chanState(chanState),
    .miso(miso), .testMode(testMode), .bankMode(bankMode),
    .gndThresh(gndThresh), .supThresh(supThresh), .softRst(softRst)
  );
endmodule

// File: rtl/spi_detector_regs_chk.sv
module spi_detector_regs_chk
  import spi_det_pkg::*;
#(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             miso,
  input logic [BANKS-1:0] bankMode,
  input logic [15:0]      gndThresh,
  input logic [15:0]      supThresh,
  input logic             softRst,
  input ctl_strobe_t      strb
);
  assert_idle_miso_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !miso);

  assert_softrst_values_R7: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (gndThresh == THR_INIT && supThresh == THR_INIT && bankMode == '0));

  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dataDone && !softRst) |=>
      ($stable(gndThresh) && $stable(supThresh) && $stable(bankMode)));

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cmdDone, strb.dataDone, strb.shiftOut}));
endmodule

bind spi_detector_regs spi_detector_regs_chk #(.BANKS(CH_COUNT/BANK_SIZE)) i_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso), .bankMode(bankMode),
  .gndThresh(gndThresh), .supThresh(supThresh), .softRst(softRst), .strb(strb)
);

// File: tb/test_spi_detector_regs.sv
`timescale 1ns/1ps
module test_spi_detector_regs;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, testMode;
  logic [31:0] chanState = '0;
  logic [3:0]  bankMode;
  logic [15:0] gndThresh, supThresh;

  int nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  spi_detector_regs i_spi_detector_regs (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .chanState(chanState), .testMode(testMode), .bankMode(bankMode),
    .gndThresh(gndThresh), .supThresh(supThresh)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spiRaw(input logic [39:0] bits, input int nbits, output logic [39:0] got);
    got = '0;
    csN = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[39-i];
      half();
      got = {got[38:0], miso};
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
    half();
    csN = 1'b1;
    mosi = 1'b0;
    half();
    half();
  endtask

  task automatic wr(input logic [6:0] addr, input int n, input logic [31:0] data);
    logic [39:0] got;
    logic [31:0] al;
    al = data << (8 * (4 - n));
    spiRaw({1'b0, addr, al}, 8 * (n + 1), got);
  endtask

  task automatic rd(input logic [6:0] addr, input int n, output logic [31:0] data);
    logic [39:0] got;
    spiRaw({1'b1, addr, 32'h0}, 8 * (n + 1), got);
    case (n)
      1: data = {24'h0, got[7:0]};
      2: data = {16'h0, got[15:0]};
      default: data = got[31:0];
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] g, s;
    logic [39:0] junk;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R7 reset state
    check("R7 reset gndThresh", 32'(gndThresh), 32'h0206);
    check("R7 reset supThresh", 32'(supThresh), 32'h0206);
    check("R7 reset bankMode", 32'(bankMode), 0);
    check("R3 reset testMode", 32'(testMode), 0);
    check("R8 idle miso", 32'(miso), 0);
    rd(7'h3A, 2, r); check("R7 R2 read gnd after reset", r, 32'h0206);
    rd(7'h3C, 2, r); check("R7 read sup after reset", r, 32'h0206);
    rd(7'h02, 1, r); check("R3 read ctrl after reset", r, 0);

    // R4 sweep of sensing modes, R11 extra byte reads 0
    for (int v = 0; v < 16; v++) begin
      wr(7'h04, 1, 32'(v));
      check("R4 bankMode output", 32'(bankMode), 32'(v));
      rd(7'h04, 2, r);
      check("R4 R11 mode readback plus zero byte", r, 32'(v) << 8);
    end
    wr(7'h04, 1, 32'h0);

    // R2 R6 threshold words
    for (int k = 0; k < 6; k++) begin
      g = 16'((k + 1) * 16'h2357) ^ 16'(k << 12);
      s = ~g;
      wr(7'h3A, 2, 32'(g));
      wr(7'h3C, 2, 32'(s));
      check("R6 gndThresh output", 32'(gndThresh), 32'(g));
      check("R6 supThresh output", 32'(supThresh), 32'(s));
      rd(7'h3A, 2, r); check("R2 gnd 16-bit read", r, 32'(g));
      rd(7'h3C, 4, r); check("R2 R11 sup 4-byte read", r, {s, 16'h0});
    end
    // R11 write bytes beyond width ignored
    wr(7'h3A, 4, 32'h1111_2222);
    check("R11 gnd ignores extra bytes", 32'(gndThresh), 32'h1111);

    // R1 read command does not write
    spiRaw({1'b1, 7'h3A, 16'hDEAD, 16'h0}, 24, junk);
    check("R1 read leaves gnd", 32'(gndThresh), 32'h1111);
    check("R1 read returns gnd", 32'(junk[15:0]), 32'h1111);

    // R5 walking ones through 32-bit status
    for (int i = 0; i < 32; i++) begin
      chanState = 32'h1 << i;
      rd(7'h78, 4, r);
      check("R5 all-states read walking one", r, 32'h1 << i);
    end
    for (int p = 0; p < 4; p++) begin
      chanState = (32'hA5C3_0F96 << (p * 5)) | (32'hA5C3_0F96 >> (32 - p * 5));
      if (p == 0) chanState = 32'hA5C3_0F96;
      for (int b = 0; b < 4; b++) begin
        rd(7'(7'h10 + 2 * b), 1, r);
        check("R5 byte state register", r, 32'(chanState[b*8 +: 8]));
      end
      rd(7'h78, 4, r);
      check("R5 all-states pattern", r, chanState);
    end

    // R3 test flag
    wr(7'h02, 1, 32'h01);
    check("R3 testMode set", 32'(testMode), 1);
    rd(7'h02, 1, r); check("R3 ctrl readback", r, 32'h01);

    // R7 software reset
    wr(7'h04, 1, 32'hA);
    wr(7'h3A, 2, 32'h1234);
    wr(7'h3C, 2, 32'h4321);
    wr(7'h02, 1, 32'hFF);
    rd(7'h02, 1, r); check("R3 ctrl upper bits read 0", r, 32'h03);
    check("R7 gnd held in reset", 32'(gndThresh), 32'h0206);
    check("R7 sup held in reset", 32'(supThresh), 32'h0206);
    check("R7 mode held in reset", 32'(bankMode), 0);
    check("R7 ctrl kept testMode", 32'(testMode), 1);
    wr(7'h3A, 2, 32'h5555);
    check("R7 write blocked in reset", 32'(gndThresh), 32'h0206);
    wr(7'h02, 1, 32'h00);
    check("R7 after release gnd", 32'(gndThresh), 32'h0206);
    check("R3 testMode cleared", 32'(testMode), 0);
    wr(7'h3A, 2, 32'h5556);
    check("R7 writes resume", 32'(gndThresh), 32'h5556);

    // R10 writes to read-only and unmapped addresses
    wr(7'h3C, 2, 32'h7A7B);
    wr(7'h04, 1, 32'h5);
    wr(7'h10, 1, 32'hFF); wr(7'h12, 1, 32'hFF);
    wr(7'h14, 1, 32'hFF); wr(7'h16, 1, 32'hFF);
    wr(7'h78, 4, 32'hFFFF_FFFF);
    wr(7'h7F, 2, 32'hFFFF); wr(7'h00, 1, 32'hFF); wr(7'h3B, 1, 32'hFF);
    check("R10 gnd unchanged", 32'(gndThresh), 32'h5556);
    check("R10 sup unchanged", 32'(supThresh), 32'h7A7B);
    check("R10 mode unchanged", 32'(bankMode), 32'h5);
    check("R10 testMode unchanged", 32'(testMode), 0);
    rd(7'h02, 1, r); check("R10 ctrl unchanged", r, 0);

    // R11 unmapped reads
    chanState = 32'hFFFF_FFFF;
    rd(7'h00, 1, r); check("R11 unmapped 0x00", r, 0);
    rd(7'h03, 1, r); check("R11 unmapped 0x03", r, 0);
    rd(7'h3B, 1, r); check("R11 unmapped 0x3B", r, 0);
    rd(7'h7F, 4, r); check("R11 unmapped 0x7F", r, 0);
    rd(7'h11, 1, r); check("R11 unmapped 0x11", r, 0);

    // R9 aborted transfers
    spiRaw({1'b0, 7'h3A, 32'h0}, 5, junk);
    check("R9 abort in command", 32'(gndThresh), 32'h5556);
    spiRaw({1'b0, 7'h3A, 8'h77, 8'h88, 16'h0}, 20, junk);
    check("R9 first byte kept, partial dropped", 32'(gndThresh), 32'h7756);
    spiRaw({1'b1, 7'h78, 32'h0}, 12, junk);
    check("R8 miso low after aborted read", 32'(miso), 0);
    check("R8 R5 first bits of aborted read", 32'(junk[3:0]), 32'hF);
    wr(7'h3C, 2, 32'h0C0D);
    check("R9 framing recovers", 32'(supThresh), 32'h0C0D);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule